// File: doc/BRIEF.md
# CPU Core Power-Up Sequencer

This block brings one secondary processor core out of its powered-off state after a single start request. It first turns on the core's voltage rail by driving a fixed rail-control byte. It waits for the rail to settle. It then walks a 9-bit core power-control word through a fixed series of changes to the clamp, sleep and power-on-reset bits. Every step is held for at least its own minimum time before the next step is taken.

All waits are counted in clock cycles. Each count is worked out when the design is built, from a clock-frequency parameter, by rounding the required time up to whole cycles (at least one cycle). The busy flag is high while the sequence runs. The done flag pulses once, in the same cycle that the final word appears. The final word is then held until reset, and any further start requests are ignored.

Top module: `core_pwrup_seq`

## Requirements
- R1: While the synchronous active-low reset is applied, the outputs read as follows: `core_ctl` is 0, `rail_ctl` is 0, `busy` is 0 and `done` is 0.
- R2: When `start` is high in idle, the next clock edge sets `rail_ctl` to 8'hA4 and raises `busy`. `core_ctl` stays 0 at that edge.
- R3: `core_ctl` stays 0 until `rail_ctl` has read 8'hA4 for ceil(512 us × CLK_HZ) cycles. That is 51200 cycles at 100 MHz. Whenever `core_ctl` is non-zero, `rail_ctl` reads 8'hA4.
- R4: The bits of `core_ctl` have these meanings: bit 8 is the PLL clamp, bit 7 is core powered-up, bit 5 is the core power-on reset, bit 4 is the core reset, bit 3 is the L2 data sleep and bit 0 is the output clamp. The first non-zero word is 9'h109, which has the PLL clamp, L2 sleep and output clamp bits set.
- R5: `core_ctl` takes these values in this order, with no others: 9'h109, 9'h101, 9'h121, 9'h120, 9'h100, 9'h180.
- R6: Each word is held for exactly its minimum time, rounded up to whole cycles and never less than one cycle. The minimum times are: 9'h109 for 1 cycle, 9'h101 for 300 ns, 9'h121 for 2 us, 9'h120 for 2 us and 9'h100 for 100 us. At 100 MHz these are 1, 30, 200, 200 and 10000 cycles.
- R7: The core reset bit (bit 4 of `core_ctl`) is never set.
- R8: `done` is high for exactly one cycle. That cycle is the first one in which `core_ctl` reads 9'h180, and `busy` is already 0 in it.
- R9: A `start` that arrives while `busy` is high has no effect on the sequence or its timing. After completion, `start` has no effect: `core_ctl` stays 9'h180 and `rail_ctl` stays 8'hA4 until reset.
- R10: A reset applied in the middle of the sequence returns the block to idle with all outputs zero. The block then stays idle until the next `start`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request to begin power-up (sampled while idle) |
| busy | output | 1 | High from the start request until the final word is written |
| done | output | 1 | One-cycle pulse with the final control word |
| rail_ctl | output | 8 | Voltage-rail control byte (0 off, 8'hA4 on) |
| core_ctl | output | 9 | Core power-control word |

## Verification
A scoreboard records every change on the rail byte and the control word. It checks each value and the exact number of cycles since the previous change. A design that skipped a step, swapped two steps, cut a wait short by one cycle, or padded a wait would each produce a value mismatch or a gap mismatch. A second start is sent a few cycles into the rail wait. A design that restarted on it would lengthen the first gap by those cycles, and the scoreboard would catch it. After completion the bench sends another start and checks that the final word holds and that done pulsed only once. A reset part-way through the sequence must clear everything, and the block must stay idle afterwards.

// File: rtl/core_pwrup_pkg.sv
// Shared definitions for the core power-up sequencer: control-word bit
// positions, the rail-on code, the step encoding and the time-to-cycle
// conversion used to size every dwell.
package core_pwrup_pkg;

    localparam int CTL_W    = 9;
    localparam int RAIL_W   = 8;

    // Bit positions inside the core power-control word.
    localparam int B_PLL_CLAMP = 8;
    localparam int B_PWRD_UP   = 7;
    localparam int B_POR       = 5;
    localparam int B_CORE_RST  = 4;
    localparam int B_L2_SLEEP  = 3;
    localparam int B_OUT_CLAMP = 0;

    localparam logic [RAIL_W-1:0] RAIL_ON_CODE = 8'hA4;

    // Sequencer steps, in the order they are visited.
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_RAIL    = 3'd1,
        ST_PRE     = 3'd2,
        ST_L2_WAKE = 3'd3,
        ST_POR_ON  = 3'd4,
        ST_UNCLAMP = 3'd5,
        ST_POR_OFF = 3'd6,
        ST_HOLD    = 3'd7
    } seq_state_t;

    // Round a time in nanoseconds up to whole clock cycles, at least one.
    function automatic longint ns_to_cycles(input longint t_ns, input longint hz);
        longint c;
        c = (t_ns * hz + 64'd999_999_999) / 64'd1_000_000_000;
        if (c < 1) c = 1;
        return c;
    endfunction

    // Build a control word from its individual fields.
    function automatic logic [CTL_W-1:0] mk_word(input logic pll, input logic pwrd,
                                                 input logic por, input logic l2,
                                                 input logic clamp);
        logic [CTL_W-1:0] w;
        w = '0;
        w[B_PLL_CLAMP] = pll;
        w[B_PWRD_UP]   = pwrd;
        w[B_POR]       = por;
        w[B_CORE_RST]  = 1'b0;
        w[B_L2_SLEEP]  = l2;
        w[B_OUT_CLAMP] = clamp;
        return w;
    endfunction

endpackage

// File: rtl/seq_delay_counter.sv
// Down-counter that times one step's dwell.
// Assumes load_val >= 1. After a load of N, expired goes high N-1 edges
// later, so the step that owns the load lasts exactly N cycles.
module seq_delay_counter #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);

    logic [CW-1:0] cnt_q;

    // Load on a step change, otherwise count down and stop at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val - 1'b1;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // The step's time is used up once the count reaches zero.
    always_comb expired = (cnt_q == '0);

endmodule

// File: rtl/seq_step_table.sv
// Combinational table that gives, for each step, the control word, the
// rail byte and the dwell in cycles. The dwells come in as parameters
// already rounded up from the clock frequency.
module seq_step_table
    import core_pwrup_pkg::*;
#(
    parameter int CW      = 16,
    parameter int D_RAIL  = 1,
    parameter int D_PRE   = 1,
    parameter int D_L2    = 1,
    parameter int D_POR   = 1,
    parameter int D_UNCL  = 1,
    parameter int D_REL   = 1
) (
    input  seq_state_t         st,
    output logic [CTL_W-1:0]   word,
    output logic [RAIL_W-1:0]  rail,
    output logic [CW-1:0]      dwell
);

    // Decode the step into its word, rail byte and dwell.
    always_comb begin
        rail  = RAIL_ON_CODE;
        dwell = CW'(1);
        word  = '0;
        unique case (st)
            ST_IDLE: begin
                rail = '0;
            end
            ST_RAIL: begin
                dwell = CW'(D_RAIL);
            end
            ST_PRE: begin
                word  = mk_word(1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
                dwell = CW'(D_PRE);
            end
            ST_L2_WAKE: begin
                word  = mk_word(1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
                dwell = CW'(D_L2);
            end
            ST_POR_ON: begin
                word  = mk_word(1'b1, 1'b0, 1'b1, 1'b0, 1'b1);
                dwell = CW'(D_POR);
            end
            ST_UNCLAMP: begin
                word  = mk_word(1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
                dwell = CW'(D_UNCL);
            end
            ST_POR_OFF: begin
                word  = mk_word(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
                dwell = CW'(D_REL);
            end
            ST_HOLD: begin
                word  = mk_word(1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
            end
            default: begin
                rail = '0;
            end
        endcase
    end

endmodule

// File: rtl/core_pwrup_seq.sv
// Power-up sequencer for one secondary core.
// A start pulse in idle turns the rail on. The block then steps the core
// control word through a fixed order, holding each step for a dwell
// rounded up from CLK_HZ. After the final word the block holds until
// reset. Assumes start is synchronous to clk.
module core_pwrup_seq
    import core_pwrup_pkg::*;
#(
    parameter longint CLK_HZ    = 100_000_000,
    parameter longint T_RAIL_NS = 512_000,
    parameter longint T_PRE_NS  = 0,
    parameter longint T_L2_NS   = 300,
    parameter longint T_POR_NS  = 2_000,
    parameter longint T_UNCL_NS = 2_000,
    parameter longint T_REL_NS  = 100_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              busy,
    output logic              done,
    output logic [7:0]        rail_ctl,
    output logic [8:0]        core_ctl
);

    localparam int D_RAIL = int'(ns_to_cycles(T_RAIL_NS, CLK_HZ));
    localparam int D_PRE  = int'(ns_to_cycles(T_PRE_NS,  CLK_HZ));
    localparam int D_L2   = int'(ns_to_cycles(T_L2_NS,   CLK_HZ));
    localparam int D_POR  = int'(ns_to_cycles(T_POR_NS,  CLK_HZ));
    localparam int D_UNCL = int'(ns_to_cycles(T_UNCL_NS, CLK_HZ));
    localparam int D_REL  = int'(ns_to_cycles(T_REL_NS,  CLK_HZ));
    localparam int M1     = (D_RAIL > D_PRE) ? D_RAIL : D_PRE;
    localparam int M2     = (D_L2   > D_POR) ? D_L2   : D_POR;
    localparam int M3     = (D_UNCL > D_REL) ? D_UNCL : D_REL;
    localparam int M12    = (M1 > M2) ? M1 : M2;
    localparam int D_MAX  = (M12 > M3) ? M12 : M3;
    localparam int CW     = $clog2(D_MAX + 1);

    seq_state_t         state_q, state_nxt;
    logic               tmr_expired, go, running;
    logic [CTL_W-1:0]   nxt_word;
    logic [RAIL_W-1:0]  nxt_rail;
    logic [CW-1:0]      nxt_dwell;
    logic [CTL_W-1:0]   ctl_q;
    logic [RAIL_W-1:0]  rail_q;
    logic               done_q;

    // A step is running in every state except idle and hold.
    always_comb running = (state_q != ST_IDLE) && (state_q != ST_HOLD);

    // Move on when idle sees start, or when a running step's time is used up.
    always_comb begin
        go        = (state_q == ST_IDLE && start) || (running && tmr_expired);
        state_nxt = seq_state_t'(state_q + 3'd1);
    end

    seq_step_table #(
        .CW     (CW),
        .D_RAIL (D_RAIL),
        .D_PRE  (D_PRE),
        .D_L2   (D_L2),
        .D_POR  (D_POR),
        .D_UNCL (D_UNCL),
        .D_REL  (D_REL)
    ) u_table (
        .st    (state_nxt),
        .word  (nxt_word),
        .rail  (nxt_rail),
        .dwell (nxt_dwell)
    );

    seq_delay_counter #(
        .CW (CW)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (go),
        .load_val (nxt_dwell),
        .expired  (tmr_expired)
    );

    // Step register and registered outputs, all updated together on a step change.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ctl_q   <= '0;
            rail_q  <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (go) begin
                state_q <= state_nxt;
                ctl_q   <= nxt_word;
                rail_q  <= nxt_rail;
                done_q  <= (state_nxt == ST_HOLD);
            end
        end
    end

    // Drive the ports.
    always_comb begin
        busy     = running;
        done     = done_q;
        rail_ctl = rail_q;
        core_ctl = ctl_q;
    end

endmodule

// File: rtl/core_pwrup_chk.sv
// Checker for the core power-up sequencer. It watches only the ports of
// the sequencer and is bound to every instance of it.
module core_pwrup_chk
    import core_pwrup_pkg::*;
#(
    parameter longint CLK_HZ = 100_000_000
) (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       busy,
    input logic       done,
    input logic [7:0] rail_ctl,
    input logic [8:0] core_ctl
);

    localparam int N_RAIL = int'(ns_to_cycles(512_000, CLK_HZ));
    localparam int N_L2   = int'(ns_to_cycles(300, CLK_HZ));
    localparam int N_2US  = int'(ns_to_cycles(2_000, CLK_HZ));
    localparam int N_REL  = int'(ns_to_cycles(100_000, CLK_HZ));

    logic [8:0] prev_ctl;
    logic [7:0] prev_rail;
    int         since;

    // Minimum dwell owed by the word that is being left.
    function automatic int need(input logic [8:0] w);
        case (w)
            9'h000:  need = N_RAIL;
            9'h101:  need = N_L2;
            9'h121:  need = N_2US;
            9'h120:  need = N_2US;
            9'h100:  need = N_REL;
            default: need = 1;
        endcase
    endfunction

    // Count cycles since the last output change and check each dwell against its minimum (R3, R6).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_ctl  <= '0;
            prev_rail <= '0;
            since     <= 0;
        end else begin
            if (core_ctl != prev_ctl) begin
                a_r6_min_dwell: assert (since >= need(prev_ctl))
                    else $error("dwell %0d below minimum for %h", since, prev_ctl);
                since <= 1;
            end else if (rail_ctl != prev_rail) begin
                since <= 1;
            end else if (since < 32'h7fff_ffff) begin
                since <= since + 1;
            end
            prev_ctl  <= core_ctl;
            prev_rail <= rail_ctl;
        end
    end

    a_r7_core_rst_low: assert property (@(posedge clk) disable iff (!rst_n)
        !core_ctl[B_CORE_RST]);

    a_r3_rail_before_ctl: assert property (@(posedge clk) disable iff (!rst_n)
        (core_ctl != '0) |-> (rail_ctl == RAIL_ON_CODE));

    a_r2_start_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && core_ctl == '0 && rail_ctl == '0) |=>
            (busy && rail_ctl == RAIL_ON_CODE && core_ctl == '0));

    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r8_done_final: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (core_ctl == 9'h180 && !busy));

    a_r9_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && core_ctl != '0) |=> ($stable(core_ctl) && $stable(rail_ctl) && !busy));

    a_r5_after_pre: assert property (@(posedge clk) disable iff (!rst_n)
        (core_ctl == 9'h109) |=> (core_ctl == 9'h109 || core_ctl == 9'h101));

    a_r5_after_unclamp: assert property (@(posedge clk) disable iff (!rst_n)
        (core_ctl == 9'h120) |=> (core_ctl == 9'h120 || core_ctl == 9'h100));

endmodule

bind core_pwrup_seq core_pwrup_chk #(.CLK_HZ(CLK_HZ)) u_core_pwrup_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .rail_ctl (rail_ctl),
    .core_ctl (core_ctl)
);

// File: tb/test_core_pwrup_seq.sv
// Scoreboard bench for core_pwrup_seq: the driver pushes the expected
// output changes, and the monitor pops one item for each change it sees.
module test_core_pwrup_seq;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       busy, done;
    logic [7:0] rail_ctl;
    logic [8:0] core_ctl;

    int n_chk  = 0;
    int n_fail = 0;

    typedef struct {
        logic [7:0] rail;
        logic [8:0] ctl;
        int         gap;
        string      wreq;
        string      greq;
    } exp_t;

    exp_t sb[$];

    always #5 clk = ~clk;

    core_pwrup_seq i_core_pwrup_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .busy     (busy),
        .done     (done),
        .rail_ctl (rail_ctl),
        .core_ctl (core_ctl)
    );

    // Minimum cycles for a time at 100 MHz, rounded up, at least one.
    function automatic int cyc_for(input longint ns);
        longint c;
        c = (ns * 64'd100_000_000 + 64'd999_999_999) / 64'd1_000_000_000;
        return (c < 1) ? 1 : int'(c);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] r, input logic [8:0] c, input int g,
                        input string wr, input string gr);
        exp_t e;
        e.rail = r; e.ctl = c; e.gap = g; e.wreq = wr; e.greq = gr;
        sb.push_back(e);
    endtask

    // Push the whole expected sequence, up to and including the word 'last'.
    task automatic push_seq(input logic [8:0] last);
        push(8'hA4, 9'h000, 0, "R2", "");
        push(8'hA4, 9'h109, cyc_for(512_000), "R4", "R3");
        if (last == 9'h109) return;
        push(8'hA4, 9'h101, 1, "R5", "R6");
        if (last == 9'h101) return;
        push(8'hA4, 9'h121, cyc_for(300), "R5", "R6");
        if (last == 9'h121) return;
        push(8'hA4, 9'h120, cyc_for(2_000), "R5", "R6");
        push(8'hA4, 9'h100, cyc_for(2_000), "R5", "R6");
        push(8'hA4, 9'h180, cyc_for(100_000), "R5", "R6");
    endtask

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    // Monitor: on every change of the outputs, pop and compare value and gap.
    initial begin
        logic [7:0] prev_r;
        logic [8:0] prev_c;
        int cyc, last;
        exp_t e;
        prev_r = '0; prev_c = '0; cyc = 0; last = 0;
        forever begin
            @(negedge clk);
            cyc++;
            if ({rail_ctl, core_ctl} != {prev_r, prev_c}) begin
                if (sb.size() == 0) begin
                    chk(1'b0, "R5", "unexpected change", {rail_ctl, core_ctl}, {prev_r, prev_c});
                end else begin
                    e = sb.pop_front();
                    chk({rail_ctl, core_ctl} == {e.rail, e.ctl}, e.wreq, "rail/word",
                        {rail_ctl, core_ctl}, {e.rail, e.ctl});
                    if (e.gap != 0)
                        chk(cyc - last == e.gap, e.greq, "dwell cycles", cyc - last, e.gap);
                end
                last   = cyc;
                prev_r = rail_ctl;
                prev_c = core_ctl;
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (190_000) @(posedge clk);
        chk(1'b0, "R5", "watchdog expired", 0, 1);
        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        // R1: outputs while reset is held.
        repeat (4) @(negedge clk);
        chk(core_ctl == 9'h000, "R1", "core_ctl in reset", core_ctl, 0);
        chk(rail_ctl == 8'h00,  "R1", "rail_ctl in reset", rail_ctl, 0);
        chk(busy == 1'b0,       "R1", "busy in reset", busy, 0);
        chk(done == 1'b0,       "R1", "done in reset", done, 0);
        rst_n = 1'b1;

        // Full sequence, with a stray start during the rail wait (R9).
        push_seq(9'h180);
        pulse_start();
        chk(busy == 1'b1, "R2", "busy after start", busy, 1);
        repeat (3) @(negedge clk);
        pulse_start();
        while (core_ctl != 9'h180) @(negedge clk);
        chk(done == 1'b1, "R8", "done with final word", done, 1);
        chk(busy == 1'b0, "R8", "busy with final word", busy, 0);
        @(negedge clk);
        chk(done == 1'b0, "R8", "done one cycle only", done, 0);

        // R9: start after completion has no effect.
        pulse_start();
        repeat (200) @(negedge clk);
        chk(core_ctl == 9'h180, "R9", "word held", core_ctl, 9'h180);
        chk(rail_ctl == 8'hA4,  "R9", "rail held", rail_ctl, 8'hA4);
        chk(busy == 1'b0,       "R9", "busy stays low", busy, 0);
        chk(done == 1'b0,       "R9", "no second done", done, 0);
        chk(sb.size() == 0,     "R5", "all steps seen", sb.size(), 0);

        // Return to idle.
        push(8'h00, 9'h000, 0, "R10", "");
        @(negedge clk) rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;

        // R10: reset in the middle of the sequence.
        push_seq(9'h121);
        pulse_start();
        while (core_ctl != 9'h121) @(negedge clk);
        repeat (20) @(negedge clk);
        push(8'h00, 9'h000, 0, "R10", "");
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(core_ctl == 9'h000, "R10", "word after reset", core_ctl, 0);
        chk(rail_ctl == 8'h00,  "R10", "rail after reset", rail_ctl, 0);
        chk(busy == 1'b0,       "R10", "busy after reset", busy, 0);
        rst_n = 1'b1;
        repeat (100) @(negedge clk);
        chk(core_ctl == 9'h000 && rail_ctl == 8'h00 && !busy, "R10", "stays idle",
            {rail_ctl, core_ctl}, 0);
        chk(sb.size() == 0, "R10", "scoreboard drained", sb.size(), 0);

        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule